// File: doc/BRIEF.md
# Double-Buffered Accelerator Context Controller

This block holds the configuration contexts for a small array of processing elements and runs the offload handshake with the host cores. A context is made of the instruction words and constant words for every processing element. The context store is split into two equal halves, and each half is large enough for the worst-case context. While one half streams its words into the array, a bus-side write port can fill the other half. The next context is therefore ready by the time the current one has been delivered, and reconfiguration time is hidden.

Host cores reach the block through a small memory-mapped register port. A command register takes a load order and a start order. A status register reports whether the array is busy, whether the last run has completed, which half was loaded last, whether a context is still streaming, whether a start is waiting, and a sticky write-error flag. Context words reach the array on a valid/ready stream that marks the final word. The array signals the end of a run with a done pulse, and the cores poll the status register to see it.

With the default parameters the store holds 1024 words of 32 bits (4 KB), arranged as two halves of 512 words.

Top module: `ctx_dbuf_ctrl`

## Requirements
- R1: After reset the status register reads 0, `ctx_valid` is low and `exec_start` is low.
- R2: A write to register address 0 with bit 0 set is a load command. Bit 2 selects the half, and bits 16 and up hold the word count minus one. From the next cycle the block streams that many words of the selected half, starting at word 0 and in rising address order. A load command issued while a load is still streaming is ignored.
- R3: A word is transferred when `ctx_valid` and `ctx_ready` are both high. While `ctx_ready` is low, `ctx_valid`, `ctx_data` and `ctx_last` hold steady. `ctx_last` is high only on the final word of a load.
- R4: The most significant bit of `wr_addr` selects the half, and the remaining bits select the word within it. A write is stored if no load is streaming, or if the load is streaming from the other half.
- R5: A write to the half that is currently streaming is not stored, and it sets status bit 3. That bit stays set until software clears it.
- R6: Writing to register address 1 with bit 3 set clears the error flag. The other status bits are unaffected by that write.
- R7: A write to address 0 with bit 1 set is a start command. While a load is streaming, or when the same write also carries a load, the start waits and status bit 5 is high. `exec_start` pulses two cycles after the cycle in which the final word is accepted. With no load streaming, `exec_start` pulses two cycles after the command write.
- R8: `exec_start` is a one-cycle pulse, and status bit 0 (busy) is high from that cycle. An `exec_done` pulse while busy clears bit 0 and sets status bit 1 (done).
- R9: A start command clears status bit 1.
- R10: A start command issued while busy is ignored. No extra `exec_start` follows, and status bit 5 stays low.
- R11: Status bit 2 shows the half named by the most recently accepted load. Status bit 4 is high while a load streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Context write strobe from the bus side |
| wr_addr | input | 10 | Context word address; the MSB selects the half |
| wr_data | input | 32 | Context word to store |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 command, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Status when `reg_addr` is 1, otherwise 0 |
| ctx_valid | output | 1 | Context word on `ctx_data` is valid |
| ctx_ready | input | 1 | Array accepts the context word |
| ctx_data | output | 32 | Context word to the array |
| ctx_last | output | 1 | Marks the final word of a load |
| exec_start | output | 1 | One-cycle pulse that starts the array |
| exec_done | input | 1 | Pulse from the array when a run ends |

## Verification
The assertions assume three things about the inputs: `ctx_ready` is a plain level that the array may drop at any time, `exec_done` arrives only as a single pulse after a run has begun, and load counts never exceed one half. The stimulus keeps within these limits. It drives `ctx_ready` either always high or on a fixed two-in-three pattern, pulses `exec_done` only after it has seen `exec_start`, and never asks for more than 512 words. Rejected writes are aimed on purpose at the half being streamed, while legal writes go to the other half during the same load.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int REG_W        = 32;
  localparam int CMD_LOAD_BIT  = 0;
  localparam int CMD_START_BIT = 1;
  localparam int CMD_HALF_BIT  = 2;
  localparam int CMD_CNT_LSB   = 16;

  localparam int ST_BUSY    = 0;
  localparam int ST_DONE    = 1;
  localparam int ST_HALF    = 2;
  localparam int ST_ERR     = 3;
  localparam int ST_LOADING = 4;
  localparam int ST_PENDING = 5;
  localparam int ST_W       = 6;

  localparam logic REG_CMD    = 1'b0;
  localparam logic REG_STATUS = 1'b1;

  typedef struct packed {
    logic pending;
    logic loading;
    logic err;
    logic half;
    logic done;
    logic busy;
  } status_t;

  function automatic logic [REG_W-1:0] status_word(input status_t s);
    logic [REG_W-1:0] w;
    w = '0;
    w[ST_BUSY]    = s.busy;
    w[ST_DONE]    = s.done;
    w[ST_HALF]    = s.half;
    w[ST_ERR]     = s.err;
    w[ST_LOADING] = s.loading;
    w[ST_PENDING] = s.pending;
    return w;
  endfunction
endpackage

// File: rtl/ctx_store.sv
module ctx_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ctx_streamer.sv
module ctx_streamer #(
  parameter int HALF_DEPTH = 512,
  localparam int CNT_W     = $clog2(HALF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_go,
  input  logic             load_half,
  input  logic [CNT_W-1:0] load_last_idx,
  input  logic             out_ready,
  output logic             loading,
  output logic             active_half,
  output logic [CNT_W:0]   rd_addr,
  output logic             out_valid,
  output logic             out_last,
  output logic             hs_last
);
  logic [CNT_W-1:0] ptr_q;
  logic [CNT_W-1:0] last_idx_q;
  logic             at_end;

  assign at_end    = (ptr_q == last_idx_q);
  assign out_valid = loading;
  assign out_last  = loading && at_end;
  assign hs_last   = loading && out_ready && at_end;
  assign rd_addr   = {active_half, ptr_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loading     <= 1'b0;
      active_half <= 1'b0;
      ptr_q       <= '0;
      last_idx_q  <= '0;
    end else if (load_go) begin
      loading     <= 1'b1;
      active_half <= load_half;
      ptr_q       <= '0;
      last_idx_q  <= load_last_idx;
    end else if (loading && out_ready) begin
      if (at_end) loading <= 1'b0;
      else        ptr_q   <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctx_cmd_regs.sv
module ctx_cmd_regs
  import ctx_pkg::*;
#(
  parameter int HALF_DEPTH = 512,
  localparam int CNT_W     = $clog2(HALF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             loading,
  input  logic             active_half,
  input  logic             wr_reject,
  input  logic             exec_done,
  output logic             load_go,
  output logic             load_half,
  output logic [CNT_W-1:0] load_last_idx,
  output logic             exec_start,
  output status_t          status
);
  logic cmd_wr, start_wr, fire, err_clr;
  logic busy_q, done_q, err_q, pending_q;
  logic unused_wbits;

  assign cmd_wr        = reg_we && (reg_addr == REG_CMD);
  assign load_go       = cmd_wr && reg_wdata[CMD_LOAD_BIT] && !loading;
  assign load_half     = reg_wdata[CMD_HALF_BIT];
  assign load_last_idx = reg_wdata[CMD_CNT_LSB +: CNT_W];
  assign start_wr      = cmd_wr && reg_wdata[CMD_START_BIT] && !busy_q;
  assign fire          = pending_q && !loading && !busy_q && !load_go;
  assign err_clr       = reg_we && (reg_addr == REG_STATUS) && reg_wdata[ST_ERR];
  assign unused_wbits  = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      pending_q  <= 1'b0;
      exec_start <= 1'b0;
    end else begin
      exec_start <= fire;
      if (fire)          pending_q <= 1'b0;
      else if (start_wr) pending_q <= 1'b1;
      if (fire)                   busy_q <= 1'b1;
      else if (busy_q && exec_done) busy_q <= 1'b0;
      if (start_wr)               done_q <= 1'b0;
      else if (busy_q && exec_done) done_q <= 1'b1;
      if (wr_reject)    err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_comb begin
    status.busy    = busy_q;
    status.done    = done_q;
    status.half    = active_half;
    status.err     = err_q;
    status.loading = loading;
    status.pending = pending_q;
  end

  assign reg_rdata = (reg_addr == REG_STATUS) ? status_word(status) : '0;
endmodule

// File: rtl/ctx_dbuf_ctrl.sv
module ctx_dbuf_ctrl
  import ctx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int HALF_DEPTH = 512,
  localparam int CNT_W     = $clog2(HALF_DEPTH),
  localparam int AW        = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              ctx_valid,
  input  logic              ctx_ready,
  output logic [DATA_W-1:0] ctx_data,
  output logic              ctx_last,
  output logic              exec_start,
  input  logic              exec_done
);
  logic             loading, active_half, load_go, load_half, hs_last;
  logic             wr_reject, store_we;
  logic [CNT_W-1:0] load_last_idx;
  logic [AW-1:0]    rd_addr;
  status_t          status;

  assign wr_reject = wr_en && loading && (wr_addr[AW-1] == active_half);
  assign store_we  = wr_en && !wr_reject;

  ctx_store #(.DATA_W(DATA_W), .DEPTH(2*HALF_DEPTH)) u_store (
    .clk(clk), .we(store_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(ctx_data)
  );

  ctx_streamer #(.HALF_DEPTH(HALF_DEPTH)) u_stream (
    .clk(clk), .rst_n(rst_n), .load_go(load_go), .load_half(load_half),
    .load_last_idx(load_last_idx), .out_ready(ctx_ready), .loading(loading),
    .active_half(active_half), .rd_addr(rd_addr), .out_valid(ctx_valid),
    .out_last(ctx_last), .hs_last(hs_last)
  );

  ctx_cmd_regs #(.HALF_DEPTH(HALF_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .loading(loading),
    .active_half(active_half), .wr_reject(wr_reject), .exec_done(exec_done),
    .load_go(load_go), .load_half(load_half), .load_last_idx(load_last_idx),
    .exec_start(exec_start), .status(status)
  );
endmodule

// File: rtl/ctx_dbuf_chk.sv
module ctx_dbuf_chk
  import ctx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctx_valid,
  input logic              ctx_ready,
  input logic [DATA_W-1:0] ctx_data,
  input logic              ctx_last,
  input logic              exec_start,
  input logic              exec_done,
  input logic              wr_reject,
  input logic              load_go,
  input logic              hs_last,
  input logic [AW-1:0]     rd_addr,
  input status_t           status
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_valid && !ctx_ready |=> ctx_valid && $stable(ctx_data) && $stable(ctx_last));

  assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_last |=> !status.loading);

  assert_load_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> ctx_valid && (rd_addr[AW-2:0] == '0));

  assert_reject_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> status.err);

  assert_no_start_while_loading_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> !status.loading);

  assert_busy_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> status.busy && !status.done);

  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start);

  assert_done_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status.busy && exec_done && !exec_start |=> status.done && !status.busy);
endmodule

bind ctx_dbuf_ctrl ctx_dbuf_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctx_valid(ctx_valid), .ctx_ready(ctx_ready),
  .ctx_data(ctx_data), .ctx_last(ctx_last), .exec_start(exec_start),
  .exec_done(exec_done), .wr_reject(wr_reject), .load_go(load_go),
  .hs_last(hs_last), .rd_addr(rd_addr), .status(status)
);

// File: tb/tb_ctx_dbuf_ctrl.sv
module tb_ctx_dbuf_ctrl;
  localparam int DW = 32;
  localparam int HD = 512;
  localparam int AW = 11 - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic reg_we = 1'b0, reg_addr = 1'b1;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ctx_valid, ctx_ready = 1'b1, ctx_last, exec_start, exec_done = 1'b0;
  logic [DW-1:0] ctx_data;

  ctx_dbuf_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctx_valid(ctx_valid), .ctx_ready(ctx_ready), .ctx_data(ctx_data),
    .ctx_last(ctx_last), .exec_start(exec_start), .exec_done(exec_done)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  int checks = 0, errors = 0;
  int exec_cnt = 0, exec_cyc = 0, last_cyc = 0;
  int ready_mode = 0;
  logic [DW:0]   exp_q[$];
  logic [DW-1:0] model [2*HD];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ctx_valid && ctx_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected word", ctx_data, 0);
      else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        check(ctx_data == e[DW-1:0], "R2 word", ctx_data, e[DW-1:0]);
        check(ctx_last == e[DW], "R3 last flag", {31'b0, ctx_last}, {31'b0, e[DW]});
        if (ctx_last) last_cyc = cyc;
      end
    end
    if (rst_n && exec_start) begin
      exec_cnt++;
      exec_cyc = cyc;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      ctx_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end
  end

  task automatic dma_wr(input int a, input logic [DW-1:0] d, input bit stored);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a[AW-1:0]; wr_data = d;
    if (stored) model[a] = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic reg_wr(input logic a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 1'b1;
  endtask

  task automatic rd_status(output logic [31:0] v);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic load(input bit half, input int cnt, input bit start);
    for (int i = 0; i < cnt; i++)
      exp_q.push_back({(i == cnt - 1), model[half*HD + i]});
    reg_wr(1'b0, ((cnt - 1) << 16) | (half << 2) | (start << 1) | 1);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(posedge clk); #1; exec_done = 1'b1;
    @(posedge clk); #1; exec_done = 1'b0;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    logic [31:0] s;
    int n0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(reg_rdata == 0, "R1 status", reg_rdata, 0);
    check(!ctx_valid && !exec_start, "R1 outputs", {ctx_valid, exec_start}, 0);

    // R4: fill half0 while idle
    for (int i = 0; i < 8; i++) dma_wr(i, 32'hA000_0000 + i * 7, 1'b1);

    // R2/R3 under backpressure, R5 reject, R4 other half accepted
    ready_mode = 1;
    load(1'b0, 8, 1'b0);
    dma_wr(2, 32'hDEAD_BEEF, 1'b0);
    for (int i = 0; i < 6; i++) dma_wr(HD + i, 32'hB100_0000 + i * 3, 1'b1);
    wait_idle();
    rd_status(s);
    check(s[3] == 1'b1, "R5 error set", s, 32'h8);
    check(s[2] == 1'b0 && s[4] == 1'b0, "R11 half0 idle", s, 0);

    // R6
    reg_wr(1'b1, 32'h8);
    rd_status(s);
    check(s[3] == 1'b0, "R6 error cleared", s, 0);

    // R7 pending start with load, R12 second load ignored, R11 half bit
    ready_mode = 1;
    load(1'b1, 6, 1'b1);
    rd_status(s);
    check(s[5] && s[4] && s[2], "R7 pending and R11 loading half1", s, 32'h34);
    reg_wr(1'b0, (3 << 16) | 1);   // load half0 while loading: ignored (R12 in brief as part of R2)
    rd_status(s);
    check(s[2] == 1'b1, "R2 ignored load keeps half", s, 32'h4);
    wait_idle();
    check(exec_cnt == 1, "R7 exec count", exec_cnt, 1);
    check(exec_cyc == last_cyc + 2, "R7 exec timing", exec_cyc, last_cyc + 2);
    rd_status(s);
    check(s[0] && !s[1] && !s[5], "R8 busy after start", s, 32'h5);

    // R10 start while busy ignored
    reg_wr(1'b0, 32'h2);
    rd_status(s);
    check(s[5] == 1'b0, "R10 no pending", s, 0);
    pulse_done();
    repeat (3) @(negedge clk);
    check(exec_cnt == 1, "R10 no extra start", exec_cnt, 1);
    rd_status(s);
    check(!s[0] && s[1], "R8 done set", s, 32'h2);

    // R9 done clears on start, immediate start timing R7
    ready_mode = 0;
    n0 = cyc;
    reg_wr(1'b0, 32'h2);
    rd_status(s);
    check(s[1] == 1'b0, "R9 done cleared", s, 0);
    repeat (2) @(negedge clk);
    check(exec_cnt == 2, "R7 immediate start", exec_cnt, 2);
    check(exec_cyc - n0 <= 4, "R7 immediate start delay", exec_cyc - n0, 4);
    pulse_done();
    repeat (2) @(negedge clk);
    rd_status(s);
    check(s[1] && !s[0], "R8 second done", s, 32'h2);

    // R5 rejected word absent on reload of half0
    load(1'b0, 8, 1'b0);
    wait_idle();

    // full-half boundary on half1, with concurrent writes to half0 (R4)
    for (int i = 0; i < HD; i++) dma_wr(HD + i, 32'hC000_0000 ^ (i * 32'h101), 1'b1);
    ready_mode = 1;
    load(1'b1, HD, 1'b0);
    for (int i = 0; i < 4; i++) dma_wr(i, 32'hE000_0000 + i, 1'b1);
    dma_wr(HD + 5, 32'h1234_5678, 1'b0);
    wait_idle();
    rd_status(s);
    check(s[3] == 1'b1 && s[2] == 1'b1, "R5 full-half reject flag", s, 32'hC);
    ready_mode = 0;
    load(1'b0, 4, 1'b0);
    wait_idle();
    check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);
    finish_sim();
  end
endmodule